// File: doc/BRIEF.md
# Sixteen-bit timer with compare reset

This peripheral is a 16-bit up-counter behind a byte-wide register bus. Software sets the counter one byte at a time and reads it back the same way. A six-bit control register holds the run enable, the choice between the system clock and an external count input, a bit that turns off synchronisation of that input, an oscillator-enable bit, and a two-bit prescaler select.

When the counter wraps from FFFFh to 0000h it sets a sticky overflow flag. The interrupt request is the flag gated by an enable bit. A one-cycle trigger pulse from an external compare unit clears the counter. The compare value therefore sets the counting period. A trigger clear never sets the flag. A CPU write to a counter byte in the same cycle beats the trigger.

Register map (addr_i): 0 = counter low byte, 1 = counter high byte, 2 = control, 3 = overflow flag (bit 0), 4 = interrupt enable (bit 0). Other addresses read as 00h and ignore writes.

Top module: `tmr16_cmp`

## Requirements
- R1: While running with a divide ratio of 1 in internal mode, the counter rises by one every clock edge. It goes from FFFFh to 0000h on the edge after it reads FFFFh.
- R2: The FFFFh-to-0000h wrap sets the overflow flag (address 3, bit 0) on the same edge. The flag stays set. irq_o is 1 exactly when the flag and the enable (address 4, bit 0) are both 1.
- R3: A trigger_i pulse clears the full 16-bit counter to 0000h on that edge, whether or not the timer is running. With a compare value P the count runs 0..P and repeats.
- R4: A trigger clear never sets the overflow flag, even on the edge where the counter would have wrapped.
- R5: A write to either counter byte on the same edge as a trigger pulse keeps the written byte. The other byte keeps its value and the trigger is ignored.
- R6: In unsynchronised external mode (control bits 2 and 1 both 1) trigger pulses are ignored.
- R7: Control register (address 2) layout: bits 5:4 prescaler select, bit 3 oscillator enable, bit 2 synchronisation off, bit 1 external source, bit 0 run. Bits 7:6 always read 0.
- R8: After reset, control, flag and enable read 0 and irq_o is 0.
- R9: Prescaler codes 0..3 divide count events by 1, 2, 4 and 8. The prescaler phase clears whenever a counter byte is written.
- R10: In synchronised external mode the counter counts rising edges of ext_clk_i. Each edge shows up on the third clock edge after the input rises.
- R11: With the run bit at 0 the counter holds its value.
- R12: Writing a 0 to bit 0 of address 3 clears the flag. Writing 1 has no effect. A wrap on the same edge as a clearing write leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| ext_clk_i | input | 1 | External count input |
| trigger_i | input | 1 | Compare-unit reset pulse |
| irq_o | output | 1 | Interrupt request |

## Verification
Register writes and trigger pulses take effect on the clock edge that samples them. A wrap sets the flag on that same edge, so both can be read at the following falling edge. With prescaling, an increment lands on the 2nd, 4th or 8th count edge counted from the last counter write. A synchronised external edge needs three clock edges before the count moves, and an unsynchronised one needs two. The bench drives inputs on falling edges and counts whole clock edges to the cycle where each result is due. It reads just before and just after that cycle, so an off-by-one in latency shows up as a mismatch.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd1;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd2;
  localparam logic [ADDR_W-1:0] A_FLAG   = 3'd3;
  localparam logic [ADDR_W-1:0] A_IE     = 3'd4;

  // field order matches the control register bits 5:0
  typedef struct packed {
    logic [1:0] ps;
    logic       osc_en;
    logic       nsync;
    logic       ext;
    logic       on;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/tmr16_regs.sv
module tmr16_regs
  import tmr16_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              ovf_i,
  output logic [BYTE_W-1:0] rdata_o,
  output ctrl_t             ctrl_o,
  output logic              flag_o,
  output logic              ie_o,
  output logic              wr_lo_o,
  output logic              wr_hi_o
);
  logic wr_ctrl, wr_flag, wr_ie;

  assign wr_lo_o = wr_en_i && (addr_i == A_CNT_LO);
  assign wr_hi_o = wr_en_i && (addr_i == A_CNT_HI);
  assign wr_ctrl = wr_en_i && (addr_i == A_CTRL);
  assign wr_flag = wr_en_i && (addr_i == A_FLAG);
  assign wr_ie   = wr_en_i && (addr_i == A_IE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o <= '0;
      ie_o   <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_o <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      if (wr_ie)   ie_o   <= wdata_i[0];
    end
  end

  // hardware set beats software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      flag_o <= 1'b0;
    else if (ovf_i)                   flag_o <= 1'b1;
    else if (wr_flag && !wdata_i[0])  flag_o <= 1'b0;
  end

  always_comb begin
    unique case (addr_i)
      A_CNT_LO: rdata_o = cnt_i[BYTE_W-1:0];
      A_CNT_HI: rdata_o = cnt_i[CNT_W-1:BYTE_W];
      A_CTRL:   rdata_o = BYTE_W'(ctrl_o);
      A_FLAG:   rdata_o = BYTE_W'(flag_o);
      A_IE:     rdata_o = BYTE_W'(ie_o);
      default:  rdata_o = '0;
    endcase
  end

  AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i |=> flag_o); // R2
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !wr_flag) |=> flag_o); // R2
  AST_FLAG_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_i && wr_flag && !wdata_i[0]) |=> flag_o); // R12
endmodule

// File: rtl/tmr16_tick.sv
module tmr16_tick
  import tmr16_pkg::*;
#(
  parameter int PS_W        = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  ext_clk_i,
  input  ctrl_t ctrl_i,
  input  logic  ps_clr_i,
  output logic  tick_o
);
  localparam int DIV_W = (1 << PS_W) - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   sel, rise, pulse;
  logic [DIV_W-1:0]       div_q, mask;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= ext_clk_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], ext_clk_i};
    end
  endgenerate

  // unsynchronised mode taps the first stage only
  assign sel  = ctrl_i.nsync ? sync_q[0] : sync_q[SYNC_STAGES-1];
  assign rise = sel && !prev_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sel;

  assign pulse  = ctrl_i.on && (ctrl_i.ext ? rise : 1'b1);
  assign mask   = DIV_W'((1 << ctrl_i.ps[PS_W-1:0]) - 1);
  assign tick_o = pulse && ((div_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       div_q <= '0;
    else if (ps_clr_i) div_q <= '0;
    else if (pulse)    div_q <= div_q + DIV_W'(1);
  end

  AST_PS_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && ctrl_i.ps != 2'd0) |=> (!tick_o || ctrl_i.ps != $past(ctrl_i.ps))); // R9
  AST_OFF_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_i.on |-> !tick_o); // R11
endmodule

// File: rtl/tmr16_counter.sv
module tmr16_counter
  import tmr16_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              clr_i,
  input  logic              tick_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              ovf_o
);
  logic any_wr;
  assign any_wr = wr_lo_i || wr_hi_i;
  assign ovf_o  = tick_i && !any_wr && !clr_i && (cnt_o == '1);

  // priority: byte write, then compare clear, then increment
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else if (any_wr) begin
      if (wr_lo_i) cnt_o[BYTE_W-1:0]     <= wdata_i;
      if (wr_hi_i) cnt_o[CNT_W-1:BYTE_W] <= wdata_i;
    end
    else if (clr_i)  cnt_o <= '0;
    else if (tick_i) cnt_o <= cnt_o + CNT_W'(1);
  end

  AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> (cnt_o == '0)); // R1
  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!any_wr && !clr_i) |=> (cnt_o == $past(cnt_o) || cnt_o == $past(cnt_o) + CNT_W'(1))); // R1
  AST_TRIG_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !any_wr) |=> (cnt_o == '0)); // R3
  AST_WRITE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && wr_lo_i && !wr_hi_i) |=> (cnt_o == {$past(cnt_o[CNT_W-1:BYTE_W]), $past(wdata_i)})); // R5
endmodule

// File: rtl/tmr16_cmp.sv
module tmr16_cmp
  import tmr16_pkg::*;
#(
  parameter int PS_W        = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [2:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       ext_clk_i,
  input  logic       trigger_i,
  output logic       irq_o
);
  ctrl_t            ctrl;
  logic             flag, ie, wr_lo, wr_hi, tick, ovf, trig_ok;
  logic [CNT_W-1:0] cnt;

  // compare reset unsupported while counting unsynchronised external edges
  assign trig_ok = trigger_i && !(ctrl.ext && ctrl.nsync);
  assign irq_o   = flag && ie;

  tmr16_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .cnt_i(cnt), .ovf_i(ovf), .rdata_o,
    .ctrl_o(ctrl), .flag_o(flag), .ie_o(ie),
    .wr_lo_o(wr_lo), .wr_hi_o(wr_hi)
  );

  tmr16_tick #(.PS_W(PS_W), .SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk_i, .rst_ni, .ext_clk_i,
    .ctrl_i(ctrl), .ps_clr_i(wr_lo || wr_hi), .tick_o(tick)
  );

  tmr16_counter u_cnt (
    .clk_i, .rst_ni, .wr_lo_i(wr_lo), .wr_hi_i(wr_hi), .wdata_i,
    .clr_i(trig_ok), .tick_i(tick), .cnt_o(cnt), .ovf_o(ovf)
  );

  AST_TRIG_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_ok && !flag) |=> !flag); // R4
  AST_UNSYNC_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trigger_i && ctrl.ext && ctrl.nsync && !wr_lo && !wr_hi && !tick) |=> $stable(cnt)); // R6
  AST_HOLD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl.on && !wr_lo && !wr_hi && !trig_ok) |=> $stable(cnt)); // R11
endmodule

// File: tb/tmr16_cmp_tb.sv
module tmr16_cmp_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       ext = 1'b0;
  logic       trig = 1'b0;
  logic       irq;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  tmr16_cmp u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .ext_clk_i(ext),
    .trigger_i(trig), .irq_o(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d, input logic with_trig = 1'b0);
    addr = a; wdata = d; wr_en = 1'b1; trig = with_trig;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; trig = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic rd16(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(3'd0, lo); rd(3'd1, hi);
    v = {hi, lo};
  endtask

  task automatic set_cnt(input logic [15:0] v);
    wr(3'd1, v[15:8]); wr(3'd0, v[7:0]);
  endtask

  task automatic pulse_trig();
    trig = 1'b1;
    @(posedge clk);
    @(negedge clk);
    trig = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(3'd2, d); chk("R8 ctrl", d, 0);
    rd(3'd3, d); chk("R8 flag", d, 0);
    rd(3'd4, d); chk("R8 ie", d, 0);
    chk("R8 irq", irq, 0);
  endtask

  task automatic t_ctrl_bits();
    logic [7:0] d;
    wr(3'd2, 8'hF2); rd(3'd2, d); chk("R7 reserved bits", d, 8'h32);
    wr(3'd2, 8'h00);
  endtask

  task automatic t_hold();
    logic [15:0] v;
    set_cnt(16'h1234);
    edges(20);
    rd16(v); chk("R11 hold while off", v, 16'h1234);
  endtask

  task automatic t_wrap_irq();
    logic [15:0] v; logic [7:0] d;
    set_cnt(16'hFFFD);
    wr(3'd2, 8'h01);
    rd16(v); chk("R1 start", v, 16'hFFFD);
    edges(1); rd16(v); chk("R1 step", v, 16'hFFFE);
    edges(1); rd16(v); chk("R1 at max", v, 16'hFFFF);
    rd(3'd3, d); chk("R2 flag before wrap", d, 0);
    edges(1); rd16(v); chk("R1 wrap", v, 16'h0000);
    rd(3'd3, d); chk("R2 flag on wrap", d, 1);
    wr(3'd2, 8'h00);
    chk("R2 irq gated off", irq, 0);
    wr(3'd4, 8'h01); chk("R2 irq raised", irq, 1);
    wr(3'd3, 8'h01); rd(3'd3, d); chk("R12 write 1 no effect", d, 1);
    wr(3'd3, 8'h00); rd(3'd3, d); chk("R12 clear", d, 0);
    chk("R2 irq dropped", irq, 0);
    wr(3'd4, 8'h00);
  endtask

  task automatic t_set_wins();
    logic [7:0] d;
    set_cnt(16'hFFFE);
    wr(3'd2, 8'h01);
    edges(1);
    wr(3'd3, 8'h00);
    rd(3'd3, d); chk("R12 set beats clear", d, 1);
    wr(3'd2, 8'h00);
    wr(3'd3, 8'h00);
  endtask

  task automatic t_trig_no_flag();
    logic [15:0] v; logic [7:0] d;
    set_cnt(16'hFFFE);
    wr(3'd2, 8'h01);
    edges(1);
    pulse_trig();
    rd16(v); chk("R3 trig at wrap edge", v, 0);
    rd(3'd3, d); chk("R4 no flag from trig", d, 0);
    wr(3'd2, 8'h00);
    set_cnt(16'hABCD);
    pulse_trig();
    rd16(v); chk("R3 trig while off", v, 0);
  endtask

  task automatic t_write_wins();
    logic [15:0] v;
    set_cnt(16'h1234);
    wr(3'd0, 8'h55, 1'b1);
    rd16(v); chk("R5 low write beats trig", v, 16'h1255);
    wr(3'd1, 8'h66, 1'b1);
    rd16(v); chk("R5 high write beats trig", v, 16'h6655);
  endtask

  task automatic t_period();
    logic [7:0] d; logic [7:0] exp; int bad = 0; int zeros = 0;
    set_cnt(16'h0000);
    wr(3'd2, 8'h01);
    addr = 3'd0; exp = 8'd0;
    for (int i = 0; i < 40; i++) begin
      #1;
      d = rdata;
      if (d != exp) bad++;
      if (d == 8'd0) zeros++;
      trig = (d == 8'd5);
      exp = (d == 8'd5) ? 8'd0 : d + 8'd1;
      @(posedge clk);
      @(negedge clk);
    end
    trig = 1'b0;
    wr(3'd2, 8'h00);
    chk("R3 period sequence mismatches", bad, 0);
    chk("R3 period restarts", zeros, 7);
    rd(3'd3, d); chk("R4 period no flag", d, 0);
  endtask

  task automatic t_prescale();
    logic [15:0] v;
    set_cnt(16'h0100);
    wr(3'd2, 8'h21);  // divide by 4
    edges(3); rd16(v); chk("R9 div4 before", v, 16'h0100);
    edges(1); rd16(v); chk("R9 div4 tick", v, 16'h0101);
    edges(2);
    wr(3'd0, 8'h10);  // phase cleared
    edges(3); rd16(v); chk("R9 phase clear hold", v, 16'h0110);
    edges(1); rd16(v); chk("R9 phase clear tick", v, 16'h0111);
    wr(3'd2, 8'h31);  // divide by 8
    set_cnt(16'h0000);
    edges(7); rd16(v); chk("R9 div8 before", v, 0);
    edges(1); rd16(v); chk("R9 div8 tick", v, 1);
    wr(3'd2, 8'h11);  // divide by 2
    set_cnt(16'h0000);
    edges(10); rd16(v); chk("R9 div2", v, 5);
    wr(3'd2, 8'h00);
  endtask

  task automatic t_ext_sync();
    logic [15:0] v;
    set_cnt(16'h0000);
    wr(3'd2, 8'h03);
    edges(4);
    ext = 1'b1;
    edges(1); rd16(v); chk("R10 no count after 1 edge", v, 0);
    edges(1); rd16(v); chk("R10 no count after 2 edges", v, 0);
    edges(1); rd16(v); chk("R10 count on 3rd edge", v, 1);
    ext = 1'b0; edges(3);
    for (int i = 0; i < 4; i++) begin
      ext = 1'b1; edges(3); ext = 1'b0; edges(3);
    end
    rd16(v); chk("R10 edge count", v, 5);
    pulse_trig();
    rd16(v); chk("R3 trig in sync ext", v, 0);
    wr(3'd2, 8'h00);
  endtask

  task automatic t_ext_unsync();
    logic [15:0] v;
    set_cnt(16'h0020);
    wr(3'd2, 8'h07);
    edges(4);
    for (int i = 0; i < 3; i++) begin
      ext = 1'b1; edges(3); ext = 1'b0; edges(3);
    end
    rd16(v); chk("R10 unsync edge count", v, 16'h0023);
    pulse_trig();
    rd16(v); chk("R6 trig ignored unsync", v, 16'h0023);
    wr(3'd2, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl_bits();
    t_hold();
    t_wrap_irq();
    t_set_wins();
    t_trig_no_flag();
    t_write_wins();
    t_period();
    t_prescale();
    t_ext_sync();
    t_ext_unsync();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule